// File: doc/BRIEF.md
# BCH Sector Error Fixer

This block applies the result of a BCH decode to a single 512-byte sector. It keeps that sector in a local byte buffer, together with the sector's 13 check bytes. A host fills the buffer through a byte-wide port. The host then presents the decoder's three position words and its status word, and pulses `start`. The block waits until the status word reports the decode as ready. It then unpacks up to eight 13-bit bit-error positions and flips the addressed bits in the buffer. Each correction is a read followed by a write to the same byte.

When the decoder reports more errors than the code can fix, the sector may simply be blank. A blank sector is all ones, and so is its check area, so the decoder finds no valid code word. The block therefore counts the zero bits in the data and check bytes, and stops as soon as the count passes the limit. If the count stays within the limit, the block rewrites the data area to 0xFF and reports success. Otherwise it raises a failure. When the block finishes, it gives one `done` pulse. On that pulse it presents the number of bits it flipped and the failure flag. The host then reads the repaired sector back through the same byte port.

Top module: `bch_err_fix`

## Requirements
- R1: After a synchronous reset, `done`, `fail` and `corr_cnt` are all 0.
- R2: While the block is idle, a host write (`buf_we`=1) stores `buf_wdata` at `buf_addr`. Addresses 0..511 are the data bytes and 512..524 are the check bytes. `buf_rdata` returns the byte at the address presented on the previous clock edge. A host write made while the block is busy is ignored.
- R3: After `start`, the block leaves the buffer untouched and gives no `done` until bit 15 of `ecc_stat` (ready) is 1.
- R4: The error count is `ecc_stat[13:10]`. A count of 0 ends the sector without changing the buffer, with `corr_cnt`=0 and `fail`=0.
- R5: Position k (0..7) is bits 13k+12 down to 13k of the 104-bit vector {`ecc_stat[23:16]`, `ecc_w2`, `ecc_w1`, `ecc_w0`}. Positions 2, 4 and 7 span word boundaries.
- R6: A position p below 4096 inverts bit p mod 8 of data byte p/8.
- R7: With a count n from 1 to 8, only positions 0..n-1 are used.
- R8: A used position of 4096 or more changes no byte and is not counted.
- R9: After a correction pass, `corr_cnt` equals the number of bits flipped and `fail`=0.
- R10: A count above 8 triggers the blank check. If bytes 0..524 hold 8 or fewer zero bits in total, data bytes 0..511 become 0xFF, the check bytes stay as they were, `corr_cnt`=0 and `fail`=0.
- R11: If the blank check finds more than 8 zero bits, `fail`=1, `corr_cnt`=0, and the buffer is unchanged.
- R12: `done` is a one-cycle pulse, given once per sector. `corr_cnt` and `fail` are valid from that pulse and hold their values until the next sector completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin processing one sector (accepted while idle) |
| ecc_w0 | input | 32 | Packed position bits 31:0 |
| ecc_w1 | input | 32 | Packed position bits 63:32 |
| ecc_w2 | input | 32 | Packed position bits 95:64 |
| ecc_stat | input | 32 | Status: [23:16] position bits 103:96, [15] ready, [13:10] error count |
| buf_we | input | 1 | Host byte write enable |
| buf_addr | input | 10 | Host byte address (0..524) |
| buf_wdata | input | 8 | Host write byte |
| buf_rdata | output | 8 | Registered read byte |
| done | output | 1 | One-cycle end-of-sector pulse |
| corr_cnt | output | 4 | Bits flipped in the last sector |
| fail | output | 1 | Last sector uncorrectable |

## Verification
The bench places positions on the fields that cross word boundaries. A slicing error there would flip the wrong bits, and the full-buffer compare would catch them. It gives counts smaller than the number of filled positions, and positions at 4096 and above. A design that used every slot, or that let an out-of-range position wrap into the data, would corrupt bytes and report too large a count. The blank check is run at exactly 8 zero bits, including zeros in the check bytes, and at 9. An off-by-one in that limit would either wipe a truly bad sector or fail a blank one. The bench also holds the ready bit low for a while, and writes to the buffer during a busy sector. An early start would show up as an early `done`, and an unblocked write would show up as a changed byte.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_DECODE, S_FX_RD, S_FX_WR,
    S_ER_RD, S_ER_ACC, S_ER_FILL, S_FIN
  } fix_state_e;
endpackage

// File: rtl/bch_pos_unpack.sv
// Slices the densely packed error positions out of three words plus a status tail.
module bch_pos_unpack #(
  parameter int NPOS   = 8,
  parameter int POS_W  = 13,
  parameter int WORD_W = 32,
  parameter int TAIL_W = 8
) (
  input  logic [WORD_W-1:0]           w0,
  input  logic [WORD_W-1:0]           w1,
  input  logic [WORD_W-1:0]           w2,
  input  logic [TAIL_W-1:0]           tail,
  output logic [NPOS-1:0][POS_W-1:0]  pos
);
  localparam int PACK_W = 3*WORD_W + TAIL_W;
  logic [PACK_W-1:0] pk_bits;
  assign pk_bits = {tail, w2, w1, w0};

  for (genvar g = 0; g < NPOS; g++) begin : g_slice
    assign pos[g] = pk_bits[g*POS_W +: POS_W];
  end
endmodule

// File: rtl/bch_zero_cnt.sv
// Number of cleared bits in one byte.
module bch_zero_cnt #(
  parameter int W  = 8,
  parameter int ZW = 5
) (
  input  logic [W-1:0]  din,
  output logic [ZW-1:0] zeros
);
  always_comb zeros = ZW'($countones(~din));
endmodule

// File: rtl/bch_byte_ram.sv
// Single-port byte store, read-first, registered output (block RAM style).
module bch_byte_ram #(
  parameter int DEPTH = 525,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/bch_err_fix.sv
module bch_err_fix
  import bch_fix_pkg::*;
#(
  parameter int SECT_BYTES = 512,
  parameter int ECC_BYTES  = 13,
  parameter int MAX_ERR    = 8,
  parameter int NPOS       = 8,
  parameter int POS_W      = 13,
  parameter int WORD_W     = 32,
  localparam int BUF_BYTES = SECT_BYTES + ECC_BYTES,
  localparam int AW        = $clog2(BUF_BYTES),
  localparam int CNT_W     = $clog2(MAX_ERR + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] ecc_w0,
  input  logic [WORD_W-1:0] ecc_w1,
  input  logic [WORD_W-1:0] ecc_w2,
  input  logic [WORD_W-1:0] ecc_stat,
  input  logic              buf_we,
  input  logic [AW-1:0]     buf_addr,
  input  logic [7:0]        buf_wdata,
  output logic [7:0]        buf_rdata,
  output logic              done,
  output logic [CNT_W-1:0]  corr_cnt,
  output logic              fail
);
  localparam int CNT_LSB  = 10;
  localparam int CNT_FW   = 4;
  localparam int RDY_BIT  = 15;
  localparam int TAIL_LSB = 16;
  localparam int TAIL_W   = 8;
  localparam int IW       = $clog2(NPOS);
  localparam int ZW       = $clog2(2*MAX_ERR + 1);
  localparam int BIT_LIM  = SECT_BYTES * 8;

  fix_state_e st;
  logic [WORD_W-1:0] lw0, lw1, lw2;
  logic [TAIL_W-1:0] ltail;
  logic [CNT_FW-1:0] lcnt, idx;
  logic [CNT_W-1:0]  ncorr;
  logic [ZW-1:0]     zacc, zbyte, zsum;
  logic [AW-1:0]     scan;
  logic              fail_q, busy, in_range;
  logic [NPOS-1:0][POS_W-1:0] pos_w;
  logic [POS_W-1:0]  pos_cur;
  logic [AW-1:0]     r_addr;
  logic              r_we;
  logic [7:0]        r_wd, ram_q;
  logic              unused_stat;

  assign unused_stat = ^{ecc_stat[WORD_W-1:TAIL_LSB+TAIL_W], ecc_stat[RDY_BIT-1:CNT_LSB+CNT_FW],
                         ecc_stat[CNT_LSB-1:0]};

  bch_pos_unpack #(.NPOS(NPOS), .POS_W(POS_W), .WORD_W(WORD_W), .TAIL_W(TAIL_W)) u_unpack (
    .w0(lw0), .w1(lw1), .w2(lw2), .tail(ltail), .pos(pos_w));

  bch_zero_cnt #(.W(8), .ZW(ZW)) u_zero (.din(ram_q), .zeros(zbyte));

  bch_byte_ram #(.DEPTH(BUF_BYTES), .AW(AW)) u_ram (
    .clk(clk), .we(r_we), .addr(r_addr), .wdata(r_wd), .rdata(ram_q));

  assign buf_rdata = ram_q;
  assign busy      = (st != S_IDLE);
  assign pos_cur   = pos_w[idx[IW-1:0]];
  assign in_range  = pos_cur < POS_W'(BIT_LIM);
  assign zsum      = zacc + zbyte;

  // Buffer port arbitration: host while idle, engine otherwise.
  always_comb begin
    r_addr = buf_addr;
    r_we   = buf_we & ~busy;
    r_wd   = buf_wdata;
    unique case (st)
      S_IDLE: ;
      S_FX_RD: r_addr = AW'(pos_cur >> 3);
      S_FX_WR: begin
        r_addr = AW'(pos_cur >> 3);
        r_we   = 1'b1;
        r_wd   = ram_q ^ (8'h01 << pos_cur[2:0]);
      end
      S_ER_RD, S_ER_ACC: r_addr = scan;
      S_ER_FILL: begin
        r_addr = scan;
        r_we   = 1'b1;
        r_wd   = 8'hFF;
      end
      default: r_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      st <= S_IDLE; corr_cnt <= '0; fail <= 1'b0;
      lw0 <= '0; lw1 <= '0; lw2 <= '0; ltail <= '0; lcnt <= '0;
      idx <= '0; ncorr <= '0; zacc <= '0; scan <= '0; fail_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) st <= S_WAIT;
        S_WAIT: if (ecc_stat[RDY_BIT]) begin
          lw0   <= ecc_w0;
          lw1   <= ecc_w1;
          lw2   <= ecc_w2;
          ltail <= ecc_stat[TAIL_LSB +: TAIL_W];
          lcnt  <= ecc_stat[CNT_LSB +: CNT_FW];
          st    <= S_DECODE;
        end
        S_DECODE: begin
          idx <= '0; ncorr <= '0; zacc <= '0; scan <= '0; fail_q <= 1'b0;
          if (lcnt == '0)                     st <= S_FIN;
          else if (lcnt > CNT_FW'(MAX_ERR))   st <= S_ER_RD;
          else                                st <= S_FX_RD;
        end
        S_FX_RD: begin
          if (idx == lcnt)   st  <= S_FIN;
          else if (in_range) st  <= S_FX_WR;
          else               idx <= idx + 1'b1;
        end
        S_FX_WR: begin
          ncorr <= ncorr + 1'b1;
          idx   <= idx + 1'b1;
          st    <= S_FX_RD;
        end
        S_ER_RD: st <= S_ER_ACC;
        S_ER_ACC: begin
          if (zsum > ZW'(MAX_ERR)) begin
            fail_q <= 1'b1;
            st     <= S_FIN;
          end else begin
            zacc <= zsum;
            if (scan == AW'(BUF_BYTES-1)) begin
              scan <= '0;
              st   <= S_ER_FILL;
            end else begin
              scan <= scan + 1'b1;
              st   <= S_ER_RD;
            end
          end
        end
        S_ER_FILL: begin
          if (scan == AW'(SECT_BYTES-1)) st <= S_FIN;
          else scan <= scan + 1'b1;
        end
        S_FIN: begin
          done     <= 1'b1;
          corr_cnt <= ncorr;
          fail     <= fail_q;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R12
  fail_at_done_chk: assert property (@(posedge clk) disable iff (rst) $changed(fail) |-> done);
  // R11
  fail_no_corr_chk: assert property (@(posedge clk) disable iff (rst) (done && fail) |-> corr_cnt == '0);
  // R3
  rdy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && !ecc_stat[RDY_BIT]) |=> st == S_WAIT);
  // R8
  ecc_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && r_we) |-> r_addr < AW'(SECT_BYTES));
  // R9
  corr_limit_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> corr_cnt <= CNT_W'(MAX_ERR));
endmodule

// File: tb/sim_bch_err_fix.sv
`timescale 1ns/1ps
module sim_bch_err_fix;
  localparam int NB = 525;
  localparam int SB = 512;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1, start = 1'b0, buf_we = 1'b0;
  logic [31:0] ecc_w0 = '0, ecc_w1 = '0, ecc_w2 = '0, ecc_stat = '0;
  logic [9:0]  buf_addr = '0;
  logic [7:0]  buf_wdata = '0, buf_rdata;
  logic        done, fail;
  logic [3:0]  corr_cnt;

  bch_err_fix u0 (
    .clk(clk), .rst(rst), .start(start), .ecc_w0(ecc_w0), .ecc_w1(ecc_w1),
    .ecc_w2(ecc_w2), .ecc_stat(ecc_stat), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .done(done),
    .corr_cnt(corr_cnt), .fail(fail));

  int checks = 0, failures = 0, done_seen = 0;
  logic [7:0] mdl [NB];

  typedef struct packed { logic [3:0] cnt; logic fl; } exp_t;
  exp_t sbq[$];
  exp_t cur;
  logic done_d = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every done pulse.
  always @(negedge clk) begin
    if (!rst) begin
      if (done && done_d) chk(1'b0, "R12", "done longer than one cycle", 2, 1);
      if (done) begin
        done_seen++;
        if (sbq.size() == 0) chk(1'b0, "R12", "unexpected done", 1, 0);
        else begin
          cur = sbq.pop_front();
          chk(corr_cnt == cur.cnt, "R9", "corr_cnt", corr_cnt, cur.cnt);
          chk(fail == cur.fl, "R11", "fail", fail, cur.fl);
        end
      end
    end
    done_d = done;
  end

  task automatic load_all();
    for (int i = 0; i < NB; i++) begin
      @(negedge clk); buf_we = 1'b1; buf_addr = 10'(i); buf_wdata = mdl[i];
    end
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic verify(input string req);
    int bad = 0, first = -1;
    logic [7:0] got;
    @(negedge clk); buf_addr = 10'd0;
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      got = buf_rdata;
      if (i + 1 < NB) buf_addr = 10'(i + 1);
      if (got !== mdl[i]) begin
        bad++;
        if (first < 0) begin
          first = i;
          $display("  byte %0d read %h model %h", i, got, mdl[i]);
        end
      end
    end
    chk(bad == 0, req, "buffer bytes differing", bad, 0);
  endtask

  // Driver: computes the expected result, pushes it, runs the sector.
  task automatic run(input int p[8], input int cnt, input int rdy_delay, input bit intrude, input string req);
    logic [103:0] pk;
    exp_t e;
    int n = 0, z = 0, ds0;
    for (int i = 0; i < 8; i++) pk[i*13 +: 13] = 13'(p[i]);
    if (cnt == 0) e = '{cnt: 4'd0, fl: 1'b0};
    else if (cnt > 8) begin
      for (int i = 0; i < NB; i++) z += $countones(~mdl[i]);
      if (z <= 8) begin
        for (int i = 0; i < SB; i++) mdl[i] = 8'hFF;
        e = '{cnt: 4'd0, fl: 1'b0};
      end else e = '{cnt: 4'd0, fl: 1'b1};
    end else begin
      for (int i = 0; i < cnt; i++)
        if (p[i] < 4096) begin
          mdl[p[i] / 8][p[i] % 8] = ~mdl[p[i] / 8][p[i] % 8];
          n++;
        end
      e = '{cnt: 4'(n), fl: 1'b0};
    end
    sbq.push_back(e);
    ds0 = done_seen;
    @(negedge clk);
    ecc_w0 = pk[31:0]; ecc_w1 = pk[63:32]; ecc_w2 = pk[95:64];
    ecc_stat = {8'h00, pk[103:96], (rdy_delay == 0), 1'b0, 4'(cnt), 10'h000};
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (intrude) begin
      buf_we = 1'b1; buf_addr = 10'd300; buf_wdata = ~mdl[300];
      @(negedge clk); buf_we = 1'b0;
    end
    if (rdy_delay > 0) begin
      repeat (rdy_delay) @(negedge clk);
      chk(done_seen == ds0, "R3", "done before ready", done_seen - ds0, 0);
      ecc_stat[15] = 1'b1;
    end
    while (sbq.size() != 0) @(negedge clk);
    verify(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 1'b0, "R1", "done", done, 0);
    chk(fail == 1'b0, "R1", "fail", fail, 0);
    chk(corr_cnt == 4'd0, "R1", "corr_cnt", corr_cnt, 0);
    rst = 1'b0;

    for (int i = 0; i < SB; i++) mdl[i] = 8'(i * 7 + 3);
    for (int i = SB; i < NB; i++) mdl[i] = 8'(8'hA0 + i);
    load_all();
    verify("R2");

    // R5 R6: all eight positions, including those straddling words
    run('{5, 1000, 2047, 300, 4095, 17, 2222, 3333}, 8, 0, 1'b0, "R5");
    // R7: count 2, later slots loaded with live positions
    run('{40, 41, 42, 43, 44, 45, 46, 47}, 2, 0, 1'b0, "R7");
    // R8: out-of-range positions skipped and not counted
    run('{4096, 8191, 9, 4100, 50, 51, 52, 53}, 4, 0, 1'b0, "R8");
    // R4: zero count leaves everything alone
    run('{100, 100, 100, 100, 100, 100, 100, 100}, 0, 0, 1'b0, "R4");
    // R3: ready held low for 20 cycles
    run('{777, 0, 0, 0, 0, 0, 0, 0}, 1, 20, 1'b0, "R3");

    // R10: blank sector with exactly 8 zero bits, three of them in check bytes
    for (int i = 0; i < NB; i++) mdl[i] = 8'hFF;
    mdl[3] = 8'hFE; mdl[100] = 8'hF0; mdl[520] = 8'hF8;
    load_all();
    run('{0, 0, 0, 0, 0, 0, 0, 0}, 12, 0, 1'b0, "R10");

    // R11 and R2: 9 zero bits fail; host write during busy ignored
    for (int i = 0; i < NB; i++) mdl[i] = 8'hFF;
    mdl[0] = 8'h00; mdl[524] = 8'hFE;
    load_all();
    run('{0, 0, 0, 0, 0, 0, 0, 0}, 15, 0, 1'b1, "R11");

    // R11: dense data, early stop
    for (int i = 0; i < NB; i++) mdl[i] = 8'(i * 13);
    load_all();
    run('{0, 0, 0, 0, 0, 0, 0, 0}, 9, 0, 1'b1, "R2");

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R12", "pending results", sbq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule